// File: doc/BRIEF.md
# Four-Channel Compare Timer with Watchdog Reset

This block is a memory-mapped timer. One free-running up-counter advances once for every single-cycle tick-enable pulse. The pulse comes from a fixed peripheral tick rate, nominally 3,686,400 Hz or 3,250,000 Hz, which is recorded in the `TICK_HZ` parameter. Four compare channels each hold a value. A channel registers an event when the counter steps onto that value. The counter does not reset on a match and keeps running.

An event sets the channel's pending flag only when the channel's enable bit is set. The channel's interrupt output is a level that follows the pending flag until software clears it. Software clears flags by writing ones to the status register. The last channel can also serve as a one-shot watchdog: when its arm bit is set, its event produces a one-cycle reset request and disarms the watchdog.

Software reaches all state through a word-addressed write port and a combinational read port. The register offsets are: counter at 0x00, interrupt enable at 0x04, status at 0x08, watchdog arm at 0x0C, and compare value i at 0x10 + 4*i.

Top module: `match_timer_wdog`

## Requirements
- R1: The counter (offset 0x00) rises by exactly one on each cycle with `tick_i` high and holds otherwise. It wraps from 0xFFFFFFFF to 0x00000000.
- R2: A write to offset 0x00 loads the counter. The load takes priority over a tick in the same cycle, and later ticks count on from the loaded value.
- R3: Channel i, with its compare value at offset 0x10+4*i, has an event on a tick that moves the counter onto its compare value. The counter continues past the match without resetting. Loading the counter directly onto a compare value is not an event.
- R4: An event on channel i sets status bit i (offset 0x08) only if bit i of the interrupt enable register (offset 0x04) is 1. `irq_o[i]` equals status bit i and stays high until that bit is cleared.
- R5: Writing the status register clears each bit that is written as 1 and is currently set. Bits written as 0 stay as they are.
- R6: The interrupt enable register keeps bits 11:0 of a write, and bits 31:12 read as zero. Bits 3:0 enable channels 0 to 3.
- R7: When bit 0 of the watchdog register (offset 0x0C) is 1 and channel 3 has an event, `rst_req_o` is high for exactly one cycle and bit 0 clears. This happens whatever the interrupt enable holds. With bit 0 at 0, no request is made.
- R8: After reset every register reads zero and all outputs are low. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Single-cycle count-enable pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 4 | Per-channel interrupt levels |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The compare path is swept over every channel with the match placed 1 to 4 ticks ahead, which separates an early or late event from a correct one. One case crosses the counter wrap, which separates a true equality compare from a magnitude compare. Status clearing is tried with several pending sets and masks, showing that only written-and-pending bits fall. The watchdog is run both armed and disarmed with interrupts off, which distinguishes the reset path from the interrupt path and confirms its one-shot disarm.

// File: rtl/mt_pkg.sv
package mt_pkg;
    // Byte offsets of the register file
    localparam int unsigned OFS_COUNT  = 'h00;
    localparam int unsigned OFS_IEN    = 'h04;
    localparam int unsigned OFS_STAT   = 'h08;
    localparam int unsigned OFS_WDOG   = 'h0C;
    localparam int unsigned OFS_MATCH  = 'h10;
    localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nx_o,
    output logic             adv_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign cnt_nx_o = cnt_q + CNT_W'(1);
    assign adv_o    = tick_i && !load_i;
    assign cnt_o    = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)      cnt_d = load_val_i;
        else if (tick_i) cnt_d = cnt_nx_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q)); // R1
    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i))); // R2
endmodule

// File: rtl/mt_match_chan.sv
module mt_match_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] cnt_nx_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] match_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] match_d, match_q;

    always_comb begin
        match_d = match_q;
        if (wr_i) match_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= match_d;
    end

    assign match_o = match_q;
    assign hit_o   = adv_i && (cnt_nx_i == match_q);

    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(match_q)); // R3
endmodule

// File: rtl/match_timer_wdog.sv
module match_timer_wdog #(
    parameter int CNT_W   = 32,
    parameter int NCH     = 4,
    parameter int IEN_W   = 12,
    parameter int ADDR_W  = 8,
    parameter int TICK_HZ = 3686400,
    parameter int WDOG_CH = NCH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  wdata_i,
    output logic [CNT_W-1:0]  rdata_o,
    output logic [NCH-1:0]    irq_o,
    output logic              rst_req_o
);
    import mt_pkg::*;

    localparam int TICKS_PER_MS = TICK_HZ / 1000;

    typedef struct packed {
        logic [NCH-1:0]   stat;
        logic [IEN_W-1:0] ien;
        logic             wdog;
        logic             req;
    } regs_t;

    regs_t r_d, r_q;

    logic             load_cnt, wr_ien, wr_stat, wr_wdog, adv;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] match_val [NCH];
    logic [NCH-1:0]   hit, clr;

    assign load_cnt = wr_en_i && (addr_i == ADDR_W'(OFS_COUNT));
    assign wr_ien   = wr_en_i && (addr_i == ADDR_W'(OFS_IEN));
    assign wr_stat  = wr_en_i && (addr_i == ADDR_W'(OFS_STAT));
    assign wr_wdog  = wr_en_i && (addr_i == ADDR_W'(OFS_WDOG));

    mt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_cnt),
        .load_val_i(wdata_i), .cnt_o(cnt_q), .cnt_nx_o(cnt_nx), .adv_o(adv)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic wr_m;
        assign wr_m = wr_en_i && (addr_i == ADDR_W'(OFS_MATCH + WORD_BYTES * i));
        mt_match_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_i(wr_m), .wdata_i(wdata_i),
            .cnt_nx_i(cnt_nx), .adv_i(adv), .match_o(match_val[i]), .hit_o(hit[i])
        );

        AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[i]) |-> ($past(r_q.ien[i]) && $past(hit[i]))); // R4
        AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat && wdata_i[i] && !hit[i]) |=> !irq_o[i]); // R5
    end

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        clr     = wr_stat ? (wdata_i[NCH-1:0] & r_q.stat) : '0;
        r_d.stat = (r_q.stat & ~clr) | (hit & r_q.ien[NCH-1:0]);
        if (wr_ien)  r_d.ien  = wdata_i[IEN_W-1:0];
        if (wr_wdog) r_d.wdog = wdata_i[0];
        if (hit[WDOG_CH] && r_q.wdog) begin
            r_d.req  = 1'b1;
            r_d.wdog = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_COUNT)) rdata_o = cnt_q;
        if (addr_i == ADDR_W'(OFS_IEN))   rdata_o = CNT_W'(r_q.ien);
        if (addr_i == ADDR_W'(OFS_STAT))  rdata_o = CNT_W'(r_q.stat);
        if (addr_i == ADDR_W'(OFS_WDOG))  rdata_o = CNT_W'(r_q.wdog);
        for (int i = 0; i < NCH; i++)
            if (addr_i == ADDR_W'(OFS_MATCH + WORD_BYTES * i)) rdata_o = match_val[i];
    end

    assign irq_o     = r_q.stat;
    assign rst_req_o = r_q.req;

    AST_WDOG_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !r_q.wdog); // R7
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o); // R7
    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(r_q.wdog) && $past(hit[WDOG_CH]))); // R7
    initial assert (TICKS_PER_MS > 0 && NCH <= IEN_W && WDOG_CH < NCH);
endmodule

// File: tb/sim_match_timer_wdog.sv
module sim_match_timer_wdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;
    logic        rst_req;
    int checks = 0, fails = 0, req_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    match_timer_wdog u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) req_seen++;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [31:0] d, bit t = 0);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1; tick = t;
        @(negedge clk); wr = 1'b0; tick = 1'b0;
    endtask

    task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        logic [31:0] v, base, mv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state and unmapped offsets
        for (int a = 0; a < 8; a++) begin
            rd_reg(8'(a * 4), v); chk("R8 reset value", v, 32'h0);
        end
        chk("R8 irq reset", {28'h0, irq}, 32'h0);
        chk("R8 req reset", {31'h0, rst_req}, 32'h0);
        rd_reg(8'h40, v); chk("R8 unmapped", v, 32'h0);
        rd_reg(8'hFC, v); chk("R8 unmapped", v, 32'h0);
        // R6
        wr_reg(8'h04, 32'hFFFF_FFFF); rd_reg(8'h04, v); chk("R6 enable width", v, 32'h0000_0FFF);
        wr_reg(8'h04, 32'h0000_0000);
        for (int i = 0; i < 4; i++) wr_reg(8'(16 + 4 * i), 32'h7000_0000 + 32'(i));
        // R1
        ticks(10); rd_reg(8'h00, v); chk("R1 count", v, 32'd10);
        repeat (5) @(negedge clk); rd_reg(8'h00, v); chk("R1 hold", v, 32'd10);
        // R1/R2 wrap and load
        wr_reg(8'h00, 32'hFFFF_FFFE); ticks(3); rd_reg(8'h00, v); chk("R1 wrap", v, 32'h1);
        wr_reg(8'h00, 32'h0000_1234, 1'b1); rd_reg(8'h00, v); chk("R2 load beats tick", v, 32'h1234);
        ticks(2); rd_reg(8'h00, v); chk("R2 continue", v, 32'h1236);
        // R3/R4 sweep channels and distances
        wr_reg(8'h04, 32'hF);
        for (int ch = 0; ch < 4; ch++) begin
            for (int d = 1; d <= 4; d++) begin
                base = 32'h1000_0000 * (ch + 1) + 32'(d * 64);
                mv = base + 32'(d);
                wr_reg(8'(16 + 4 * ch), mv);
                wr_reg(8'h00, base);
                ticks(d - 1);
                chk("R3 early event", {28'h0, irq}, 32'h0);
                ticks(1);
                chk("R3 event on match", {28'h0, irq}, 32'h1 << ch);
                rd_reg(8'h08, v); chk("R4 status bit", v, 32'h1 << ch);
                ticks(1);
                chk("R4 level held", {28'h0, irq}, 32'h1 << ch);
                rd_reg(8'h00, v); chk("R3 no counter reset", v, mv + 32'h1);
                wr_reg(8'h08, 32'hF);
                chk("R5 cleared", {28'h0, irq}, 32'h0);
            end
        end
        // R3 across wrap on channel 3
        wr_reg(8'h1C, 32'h1); wr_reg(8'h00, 32'hFFFF_FFFD);
        ticks(3); chk("R3 pre-wrap", {28'h0, irq}, 32'h0);
        ticks(1); chk("R3 wrap match", {28'h0, irq}, 32'h8);
        wr_reg(8'h08, 32'h8);
        // R4 disabled channel
        wr_reg(8'h04, 32'hE); wr_reg(8'h10, 32'h500); wr_reg(8'h00, 32'h4FF);
        ticks(1); rd_reg(8'h08, v); chk("R4 disabled no status", v, 32'h0);
        // R5 masking
        wr_reg(8'h04, 32'hF); wr_reg(8'h10, 32'h301); wr_reg(8'h14, 32'h302);
        wr_reg(8'h00, 32'h300); ticks(2);
        rd_reg(8'h08, v); chk("R5 two pending", v, 32'h3);
        wr_reg(8'h08, 32'h2); rd_reg(8'h08, v); chk("R5 clear one", v, 32'h1);
        wr_reg(8'h08, 32'hC); rd_reg(8'h08, v); chk("R5 zero mask", v, 32'h1);
        chk("R5 irq follows", {28'h0, irq}, 32'h1);
        wr_reg(8'h08, 32'h1); rd_reg(8'h08, v); chk("R5 clear last", v, 32'h0);
        // R3 load onto value not an event
        wr_reg(8'h00, 32'h301); rd_reg(8'h08, v); chk("R3 load no event", v, 32'h0);
        // R7 watchdog armed
        wr_reg(8'h04, 32'h0); wr_reg(8'h0C, 32'h1); wr_reg(8'h1C, 32'h202);
        wr_reg(8'h00, 32'h200); req_seen = 0;
        ticks(1); chk("R7 no early req", {31'h0, rst_req}, 32'h0);
        ticks(1); chk("R7 req high", {31'h0, rst_req}, 32'h1);
        chk("R7 irq off", {28'h0, irq}, 32'h0);
        @(negedge clk); chk("R7 one cycle", {31'h0, rst_req}, 32'h0);
        rd_reg(8'h0C, v); chk("R7 disarmed", v, 32'h0);
        chk("R7 pulse count", 32'(req_seen), 32'h1);
        // R7 disarmed
        wr_reg(8'h00, 32'h200); ticks(3);
        chk("R7 no req unarmed", 32'(req_seen), 32'h1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule